// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog timer that escalates through four stages. Software programs a tick limit and an action for each stage through a small register port, then arms the timer. Every qualified tick advances a shared counter. When the counter reaches the limit of the current stage, that stage's action fires and the sequencer moves on. The possible actions are an interrupt, a reset pulse to selected CPUs, a system reset pulse or an always-on-domain reset pulse. Writing the feed register restarts the sequence from stage 0 with an empty counter.

Configuration registers are guarded by a 32-bit unlock key. A boot-arm bit keeps the timer running even when the main enable is clear. A pause-in-sleep option freezes counting while the sleep input is high. Reset pulse widths are chosen from eight settings between 100 ns and 3200 ns. The block makes them by counting system clock cycles of `CLK_NS` nanoseconds each.

Top module: `stage_wdt`

## Requirements
- R1: After reset every output is low, and every register reads back 0: control, limits, key status, interrupt enable and interrupt status.
- R2: Writes to control (address 0), the limits (addresses 1 to 4) and interrupt enable (address 6) take effect only while the block is unlocked. Writing 32'h6B1DE02C to address 5 unlocks it. Writing 0 to address 5 locks it. Any other value written to address 5 changes nothing. Address 5 reads back 1 when unlocked.
- R3: Control bits 0 (run) or 1 (boot-arm) arm the timer. Stage s expires on the L-th counted tick after it becomes current, where L is the limit at address 1+s and a limit of 0 counts as 1. An expiry with the interrupt action moves to stage s+1, and stage 3 moves back to stage 0.
- R4: Stage s takes its action from control bits [13+3s+2:13+3s]. The codes are 1 interrupt, 2 CPU reset, 3 system reset and 4 always-on reset. Codes 0, 5, 6 and 7 mean off. An armed stage that is off advances to the next stage within one clock, without counting, and its stored limit still reads back unchanged.
- R5: Writing a value with bit 0 set to address 8 (feed, writable while locked) clears the counter and returns the timer to stage 0. No action fires in that cycle.
- R6: With run clear and boot-arm set, the timer still counts and fires. Clearing run leaves boot-arm as written. With both bits clear, the timer does not count.
- R7: With control bit 2 (pause-in-sleep) set and sleep_i high, ticks are not counted. With bit 2 clear, sleep_i has no effect.
- R8: An interrupt expiry sets the status flag at address 7. Writing 1 to bit 0 of address 7 (writable while locked) clears it, and a set in the same cycle wins over the clear. irq_o equals status AND interrupt enable (address 6, bit 0) AND control bit 4.
- R9: When interrupt enable and control bit 3 are set, irq_edge_o is high for the one clock that follows each interrupt expiry.
- R10: A CPU-reset expiry drives cpu_rst_o[i] high for every CPU whose mask bit (control bit 5+i) is set. The pulse starts on the clock after the expiry and lasts the width given by control bits [9:7]. The stage and the counter return to 0.
- R11: A system-reset or always-on-reset expiry drives sys_rst_o or aon_rst_o for the width given by control bits [12:10]. Width codes 0 to 7 select 100, 200, 300, 400, 500, 800, 1600 and 3200 ns, which is that time divided by CLK_NS in clocks (at least 1). The stage and the counter return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timer tick strobe |
| sleep_i | input | 1 | Sleep state of the host |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Level interrupt |
| irq_edge_o | output | 1 | One-clock interrupt strobe |
| cpu_rst_o | output | 2 | Per-CPU reset pulses |
| sys_rst_o | output | 1 | System reset pulse |
| aon_rst_o | output | 1 | Always-on domain reset pulse |

## Verification
The bench targets the off-stage skip. A design that counted through a disabled stage would raise the next interrupt late. It also targets the wrap after stage 3, where a sequencer that stuck at the last stage would fire on the wrong limit. A reset action must send the sequence back to stage 0; if it did not, the interrupt from stage 1 would appear after a single tick. It checks that a set beats a clear in the same cycle, that a feed in the middle of a stage restarts the count, and that locked writes leave the registers untouched. It also measures each reset pulse in clocks and confirms that masked CPUs stay quiet.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int NUM_STAGES = 4;
  localparam int NUM_CPU    = 2;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam int ACT_W      = 3;
  localparam int WCODE_W    = 3;
  localparam int STG_W      = $clog2(NUM_STAGES);

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h6B1D_E02C;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
  localparam logic [ADDR_W-1:0] A_LIM0     = 4'd1;
  localparam logic [ADDR_W-1:0] A_KEY      = 4'd5;
  localparam logic [ADDR_W-1:0] A_IRQ_EN   = 4'd6;
  localparam logic [ADDR_W-1:0] A_IRQ_STAT = 4'd7;
  localparam logic [ADDR_W-1:0] A_FEED     = 4'd8;

  localparam logic [ACT_W-1:0] ACT_IRQ = 3'd1;
  localparam logic [ACT_W-1:0] ACT_CPU = 3'd2;
  localparam logic [ACT_W-1:0] ACT_SYS = 3'd3;
  localparam logic [ACT_W-1:0] ACT_AON = 3'd4;

  typedef struct packed {
    logic [NUM_STAGES-1:0][ACT_W-1:0] act;
    logic [WCODE_W-1:0]               sys_w;
    logic [WCODE_W-1:0]               cpu_w;
    logic [NUM_CPU-1:0]               cpu_mask;
    logic                             lvl_en;
    logic                             edge_en;
    logic                             pause_en;
    logic                             boot_arm;
    logic                             run_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic int unsigned pulse_ns(input logic [WCODE_W-1:0] code);
    case (code)
      3'd0:    return 100;
      3'd1:    return 200;
      3'd2:    return 300;
      3'd3:    return 400;
      3'd4:    return 500;
      3'd5:    return 800;
      3'd6:    return 1600;
      default: return 3200;
    endcase
  endfunction

  function automatic int unsigned width_cycles(input logic [WCODE_W-1:0] code,
                                               input int unsigned clk_ns);
    int unsigned c;
    c = pulse_ns(code) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction
endpackage

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (start_i)         cnt_q <= len_i;   // retrigger reloads
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  AST_PULSE_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && len_i != '0) |=> pulse_o); // R10
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int LIM_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output logic [DATA_W-1:0]                 rd_data_o,
  input  logic                              irq_set_i,
  output ctrl_t                             ctrl_o,
  output logic [NUM_STAGES-1:0][LIM_W-1:0]  lim_o,
  output logic                              irq_en_o,
  output logic                              irq_stat_o,
  output logic                              feed_o
);
  ctrl_t                            ctrl_q;
  logic [NUM_STAGES-1:0][LIM_W-1:0] lim_q;
  logic                             unlocked_q, irq_en_q, irq_stat_q;
  logic                             prot_wr, clr_wr;

  assign prot_wr = wr_en_i & unlocked_q;
  assign clr_wr  = wr_en_i && (wr_addr_i == A_IRQ_STAT) && wr_data_i[0];
  assign feed_o  = wr_en_i && (wr_addr_i == A_FEED) && wr_data_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      unlocked_q <= 1'b0;
    end else if (wr_en_i && wr_addr_i == A_KEY) begin
      if (wr_data_i == UNLOCK_KEY)  unlocked_q <= 1'b1;
      else if (wr_data_i == '0)     unlocked_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      irq_en_q <= 1'b0;
    end else if (prot_wr) begin
      if (wr_addr_i == A_CTRL)   ctrl_q   <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (wr_addr_i == A_IRQ_EN) irq_en_q <= wr_data_i[0];
    end
  end

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_lim
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lim_q[s] <= '0;
      else if (prot_wr && wr_addr_i == ADDR_W'(A_LIM0 + s))
        lim_q[s] <= wr_data_i[LIM_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_stat_q <= 1'b0;
    else if (irq_set_i) irq_stat_q <= 1'b1;
    else if (clr_wr)    irq_stat_q <= 1'b0;
  end

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_CTRL:     rd_data_o[CTRL_W-1:0] = ctrl_q;
      A_KEY:      rd_data_o[0] = unlocked_q;
      A_IRQ_EN:   rd_data_o[0] = irq_en_q;
      A_IRQ_STAT: rd_data_o[0] = irq_stat_q;
      default: begin
        for (int s = 0; s < NUM_STAGES; s++)
          if (rd_addr_i == ADDR_W'(A_LIM0 + s)) rd_data_o[LIM_W-1:0] = lim_q[s];
      end
    endcase
  end

  assign ctrl_o     = ctrl_q;
  assign lim_o      = lim_q;
  assign irq_en_o   = irq_en_q;
  assign irq_stat_o = irq_stat_q;

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !unlocked_q && wr_addr_i == A_CTRL) |=> $stable(ctrl_q)); // R2
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_stat_q); // R8
  AST_KEY_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_KEY && wr_data_i == UNLOCK_KEY) |=> unlocked_q); // R2
endmodule

// File: rtl/wdt_seq.sv
module wdt_seq
  import wdt_pkg::*;
#(
  parameter int LIM_W = 32
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  ctrl_t                             ctrl_i,
  input  logic [NUM_STAGES-1:0][LIM_W-1:0]  lim_i,
  input  logic                              tick_i,
  input  logic                              sleep_i,
  input  logic                              feed_i,
  output logic                              fire_irq_o,
  output logic                              fire_cpu_o,
  output logic                              fire_sys_o,
  output logic                              fire_aon_o
);
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(NUM_STAGES - 1);

  logic [STG_W-1:0] stage_q, stage_nxt;
  logic [LIM_W-1:0] cnt_q, lim_cur;
  logic [LIM_W:0]   cnt_inc;
  logic [ACT_W-1:0] act_cur;
  logic             armed, act_off, act_rst, count_en, expire;

  assign armed    = ctrl_i.run_en | ctrl_i.boot_arm;
  assign act_cur  = ctrl_i.act[stage_q];
  assign act_off  = !(act_cur == ACT_IRQ || act_cur == ACT_CPU ||
                      act_cur == ACT_SYS || act_cur == ACT_AON);
  assign act_rst  = (act_cur == ACT_CPU) || (act_cur == ACT_SYS) || (act_cur == ACT_AON);
  assign count_en = armed && tick_i && !(ctrl_i.pause_en && sleep_i);
  assign lim_cur  = (lim_i[stage_q] == '0) ? LIM_W'(1) : lim_i[stage_q];
  assign cnt_inc  = {1'b0, cnt_q} + (LIM_W+1)'(1);
  assign expire   = count_en && !act_off && !feed_i && (cnt_inc >= {1'b0, lim_cur});
  assign stage_nxt = (stage_q == LAST_STG) ? '0 : stage_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (!armed || feed_i) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (act_off) begin
      stage_q <= stage_nxt;   // disabled stage: skip in one clock
      cnt_q   <= '0;
    end else if (expire) begin
      stage_q <= act_rst ? '0 : stage_nxt;
      cnt_q   <= '0;
    end else if (count_en) begin
      cnt_q   <= cnt_inc[LIM_W-1:0];
    end
  end

  assign fire_irq_o = expire && (act_cur == ACT_IRQ);
  assign fire_cpu_o = expire && (act_cur == ACT_CPU);
  assign fire_sys_o = expire && (act_cur == ACT_SYS);
  assign fire_aon_o = expire && (act_cur == ACT_AON);

  AST_FEED_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_i |=> (stage_q == '0 && cnt_q == '0)); // R5
  AST_OFF_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && act_off && !feed_i) |=> (cnt_q == '0 && stage_q != $past(stage_q))); // R4
  AST_PAUSE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && ctrl_i.pause_en && sleep_i && !act_off && !feed_i) |=>
    ($stable(cnt_q) && $stable(stage_q))); // R7
  AST_RST_TO_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && act_rst) |=> (stage_q == '0 && cnt_q == '0)); // R10
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fire_irq_o, fire_cpu_o, fire_sys_o, fire_aon_o})); // R4
endmodule

// File: rtl/stage_wdt.sv
module stage_wdt
  import wdt_pkg::*;
#(
  parameter int CLK_NS = 100,
  parameter int LIM_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                sleep_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic                irq_o,
  output logic                irq_edge_o,
  output logic [NUM_CPU-1:0]  cpu_rst_o,
  output logic                sys_rst_o,
  output logic                aon_rst_o
);
  localparam int unsigned MAX_PW = width_cycles(3'd7, CLK_NS);
  localparam int          PW_W   = $clog2(MAX_PW + 1);

  ctrl_t                            ctrl;
  logic [NUM_STAGES-1:0][LIM_W-1:0] lim;
  logic                             irq_en, irq_stat, feed;
  logic                             fire_irq, fire_cpu, fire_sys, fire_aon;
  logic [PW_W-1:0]                  cpu_len, sys_len;
  logic                             irq_edge_q;

  wdt_regs #(.LIM_W(LIM_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .rd_addr_i  (rd_addr_i),
    .rd_data_o  (rd_data_o),
    .irq_set_i  (fire_irq),
    .ctrl_o     (ctrl),
    .lim_o      (lim),
    .irq_en_o   (irq_en),
    .irq_stat_o (irq_stat),
    .feed_o     (feed)
  );

  wdt_seq #(.LIM_W(LIM_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_i     (ctrl),
    .lim_i      (lim),
    .tick_i     (tick_i),
    .sleep_i    (sleep_i),
    .feed_i     (feed),
    .fire_irq_o (fire_irq),
    .fire_cpu_o (fire_cpu),
    .fire_sys_o (fire_sys),
    .fire_aon_o (fire_aon)
  );

  assign cpu_len = PW_W'(width_cycles(ctrl.cpu_w, CLK_NS));
  assign sys_len = PW_W'(width_cycles(ctrl.sys_w, CLK_NS));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    wdt_pulse #(.CNT_W(PW_W)) u_cpu_pulse (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (fire_cpu && ctrl.cpu_mask[c]),
      .len_i   (cpu_len),
      .pulse_o (cpu_rst_o[c])
    );
  end

  wdt_pulse #(.CNT_W(PW_W)) u_sys_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fire_sys),
    .len_i   (sys_len),
    .pulse_o (sys_rst_o)
  );

  wdt_pulse #(.CNT_W(PW_W)) u_aon_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fire_aon),
    .len_i   (sys_len),
    .pulse_o (aon_rst_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_edge_q <= 1'b0;
    else         irq_edge_q <= fire_irq && irq_en && ctrl.edge_en;
  end

  assign irq_edge_o = irq_edge_q;
  assign irq_o      = irq_stat && irq_en && ctrl.lvl_en;

  AST_EDGE_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_irq && irq_en && ctrl.edge_en) |=> irq_edge_o); // R9
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_rst_o[0] && !(fire_cpu && ctrl.cpu_mask[0])) |=> !cpu_rst_o[0]); // R10
endmodule

// File: tb/tb_stage_wdt.sv
module tb_stage_wdt;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'h6B1D_E02C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, sleep = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, irq_edge, sys_rst, aon_rst;
  logic [1:0]  cpu_rst;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stage_wdt dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sleep_i(sleep),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq),
    .irq_edge_o(irq_edge), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst),
    .aon_rst_o(aon_rst)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_ctrl, m_irqen_w;
  longint      m_lim [4];
  logic        m_unl, m_irqen, m_stat, m_edge;
  int          m_stage;
  longint      m_cnt;
  int          m_pc [2];
  int          m_ps, m_pa;
  int          t_act, t_lim;
  logic        t_off, t_arm, t_cen, t_feed, t_exp, t_unl;

  function automatic int w_cycles(input int code);
    int ns;
    case (code)
      0: ns = 100;  1: ns = 200;  2: ns = 300;  3: ns = 400;
      4: ns = 500;  5: ns = 800;  6: ns = 1600; default: ns = 3200;
    endcase
    return (ns / 100 < 1) ? 1 : ns / 100;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_unl = 0; m_irqen = 0; m_stat = 0; m_edge = 0;
      m_stage = 0; m_cnt = 0; m_ps = 0; m_pa = 0;
      for (int i = 0; i < 4; i++) m_lim[i] = 0;
      for (int i = 0; i < 2; i++) m_pc[i] = 0;
    end else begin
      t_act  = int'((m_ctrl >> (13 + 3*m_stage)) & 32'h7);
      t_off  = !(t_act >= 1 && t_act <= 4);
      t_arm  = m_ctrl[0] | m_ctrl[1];
      t_cen  = t_arm && tick && !(m_ctrl[2] && sleep);
      t_feed = wr_en && wr_addr == 4'd8 && wr_data[0];
      t_lim  = (m_lim[m_stage] == 0) ? 1 : int'(m_lim[m_stage]);
      t_exp  = t_arm && !t_off && t_cen && !t_feed && (m_cnt + 1 >= t_lim);
      // pulses
      for (int i = 0; i < 2; i++) begin
        if (t_exp && t_act == 2 && m_ctrl[5+i]) m_pc[i] = w_cycles(int'(m_ctrl[9:7]));
        else if (m_pc[i] > 0) m_pc[i]--;
      end
      if (t_exp && t_act == 3) m_ps = w_cycles(int'(m_ctrl[12:10]));
      else if (m_ps > 0) m_ps--;
      if (t_exp && t_act == 4) m_pa = w_cycles(int'(m_ctrl[12:10]));
      else if (m_pa > 0) m_pa--;
      m_edge = t_exp && t_act == 1 && m_irqen && m_ctrl[3];
      if (t_exp && t_act == 1) m_stat = 1;
      else if (wr_en && wr_addr == 4'd7 && wr_data[0]) m_stat = 0;
      // sequencer
      if (!t_arm || t_feed) begin m_stage = 0; m_cnt = 0; end
      else if (t_off) begin m_stage = (m_stage + 1) % 4; m_cnt = 0; end
      else if (t_exp) begin m_stage = (t_act >= 2) ? 0 : (m_stage + 1) % 4; m_cnt = 0; end
      else if (t_cen) m_cnt++;
      // registers
      t_unl = m_unl;
      if (wr_en && t_unl) begin
        if (wr_addr == 4'd0) m_ctrl = wr_data & 32'h01FF_FFFF;
        if (wr_addr >= 4'd1 && wr_addr <= 4'd4) m_lim[wr_addr-1] = wr_data;
        if (wr_addr == 4'd6) m_irqen = wr_data[0];
      end
      if (wr_en && wr_addr == 4'd5) begin
        if (wr_data == KEY) m_unl = 1;
        else if (wr_data == 0) m_unl = 0;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_ctrl;
      4'd1, 4'd2, 4'd3, 4'd4: return m_lim[a-1][31:0];
      4'd5: return {31'b0, m_unl};
      4'd6: return {31'b0, m_irqen};
      4'd7: return {31'b0, m_stat};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3/R8/R9/R10/R11 model outputs",
          {irq, irq_edge, cpu_rst, sys_rst, aon_rst},
          {m_stat & m_irqen & m_ctrl[4], m_edge, m_pc[1] > 0, m_pc[0] > 0, m_ps > 0, m_pa > 0});
      chk("R2 model readback", rd_data, m_read(rd_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(input logic t, input logic w, input logic [3:0] a, input logic [31:0] d);
    tick = t; wr_en = w; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    tick = 0; wr_en = 0;
  endtask
  task automatic wr(input logic [3:0] a, input logic [31:0] d); cyc(0, 1, a, d); endtask
  task automatic tk(input int n); repeat (n) cyc(1, 0, 4'd0, 32'd0); endtask
  task automatic feed(); wr(4'd8, 32'd1); endtask
  task automatic clr(); wr(4'd7, 32'd1); endtask
  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask
  task automatic pulses(output int c0, output int c1, output int cs, output int ca);
    c0 = int'(cpu_rst[0]); c1 = int'(cpu_rst[1]); cs = int'(sys_rst); ca = int'(aon_rst);
    repeat (40) begin
      cyc(0, 0, 4'd0, 32'd0);
      c0 += int'(cpu_rst[0]); c1 += int'(cpu_rst[1]); cs += int'(sys_rst); ca += int'(aon_rst);
    end
  endtask

  function automatic logic [31:0] mk(input bit run, input bit boot, input bit pause,
      input bit edg, input bit lvl, input logic [1:0] mask, input logic [2:0] cw,
      input logic [2:0] sw, input logic [2:0] a0, input logic [2:0] a1,
      input logic [2:0] a2, input logic [2:0] a3);
    return {7'b0, a3, a2, a1, a0, sw, cw, mask, lvl, edg, pause, boot, run};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_err++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int c0, c1, cs, ca;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk("R1 outputs", {irq, irq_edge, cpu_rst, sys_rst, aon_rst}, 0);
    rd(4'd0, v); chk("R1 ctrl", v, 0);
    rd(4'd5, v); chk("R1 key status", v, 0);
    rd(4'd3, v); chk("R1 limit2", v, 0);
    // R2 lock
    wr(4'd0, 32'h0000_0060); rd(4'd0, v); chk("R2 locked ctrl write", v, 0);
    wr(4'd5, 32'h1234_5678); rd(4'd5, v); chk("R2 wrong key", v, 0);
    wr(4'd5, KEY);           rd(4'd5, v); chk("R2 unlock", v, 1);
    wr(4'd0, 32'h0000_0060); rd(4'd0, v); chk("R2 unlocked write", v, 32'h60);
    wr(4'd5, 32'd0);         rd(4'd5, v); chk("R2 relock", v, 0);
    wr(4'd0, 32'h0000_0004); rd(4'd0, v); chk("R2 relocked write ignored", v, 32'h60);
    wr(4'd2, 32'd9);         rd(4'd2, v); chk("R2 locked limit", v, 0);
    wr(4'd5, KEY);
    // R3 sequencing
    wr(4'd1, 3); wr(4'd2, 2); wr(4'd3, 2); wr(4'd4, 2); wr(4'd6, 1);
    wr(4'd0, mk(1,0,0,0,1,2'b00,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1));
    feed();
    tk(2); rd(4'd7, v); chk("R3 stage0 before limit", v, 0);
    tk(1); rd(4'd7, v); chk("R3 stage0 at limit", v, 1);
    chk("R8 level irq", irq, 1);
    clr(); chk("R8 cleared", irq, 0);
    tk(2); rd(4'd7, v); chk("R3 stage1", v, 1); clr();
    tk(2); clr(); tk(2); clr();
    tk(2); rd(4'd7, v); chk("R3 wrap stage0 not yet", v, 0);
    tk(1); rd(4'd7, v); chk("R3 wrap stage0 fires", v, 1); clr();
    // R4 off skip
    wr(4'd0, mk(1,0,0,0,1,2'b00,3'd0,3'd0,3'd1,3'd0,3'd1,3'd1));
    feed(); tk(3); clr();
    tk(1); rd(4'd7, v); chk("R4 skip no early", v, 0);
    tk(1); rd(4'd7, v); chk("R4 skipped to stage2", v, 1); clr();
    rd(4'd2, v); chk("R4 limit kept", v, 2);
    wr(4'd0, mk(1,0,0,0,1,2'b00,3'd0,3'd0,3'd1,3'd6,3'd1,3'd1));
    feed(); tk(3); clr(); tk(2); rd(4'd7, v); chk("R4 code6 off", v, 1); clr();
    // R5 feed mid stage
    feed(); tk(2); feed(); tk(2); rd(4'd7, v); chk("R5 feed restarts", v, 0);
    tk(1); rd(4'd7, v); chk("R5 after feed", v, 1); clr();
    // R8 enable and set-wins
    wr(4'd6, 0); feed(); tk(3); rd(4'd7, v);
    chk("R8 status without enable", v, 1); chk("R8 irq gated", irq, 0);
    wr(4'd6, 1); chk("R8 irq enabled", irq, 1); clr();
    feed(); tk(2); cyc(1, 1, 4'd7, 32'd1); rd(4'd7, v); chk("R8 set beats clear", v, 1); clr();
    // R9 edge
    wr(4'd0, mk(1,0,0,1,1,2'b00,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1));
    feed(); tk(2); cyc(1, 0, 4'd0, 32'd0);
    chk("R9 edge high", irq_edge, 1);
    cyc(0, 0, 4'd0, 32'd0); chk("R9 edge one clock", irq_edge, 0); clr();
    // R6 boot arm
    wr(4'd0, mk(0,1,0,0,1,2'b00,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1));
    feed(); tk(3); rd(4'd7, v); chk("R6 boot-arm counts", v, 1); clr();
    rd(4'd0, v); chk("R6 boot bit kept", v[1], 1);
    wr(4'd0, mk(0,0,0,0,1,2'b00,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1));
    tk(5); rd(4'd7, v); chk("R6 disarmed", v, 0);
    // R7 pause
    wr(4'd0, mk(1,0,1,0,1,2'b00,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1));
    sleep = 1; feed(); tk(5); rd(4'd7, v); chk("R7 paused", v, 0);
    sleep = 0; tk(3); rd(4'd7, v); chk("R7 resumed", v, 1); clr();
    wr(4'd0, mk(1,0,0,0,1,2'b00,3'd0,3'd0,3'd1,3'd1,3'd1,3'd1));
    sleep = 1; feed(); tk(3); rd(4'd7, v); chk("R7 sleep ignored", v, 1); clr(); sleep = 0;
    // R10 cpu reset
    wr(4'd2, 1);
    wr(4'd0, mk(1,0,0,0,1,2'b10,3'd3,3'd0,3'd2,3'd1,3'd1,3'd1));
    feed(); tk(2); cyc(1, 0, 4'd0, 32'd0); pulses(c0, c1, cs, ca);
    chk("R10 cpu1 width 400ns", c1, 4); chk("R10 cpu0 masked", c0, 0);
    tk(1); rd(4'd7, v); chk("R10 back to stage0", v, 0);
    wr(4'd0, mk(1,0,0,0,1,2'b11,3'd6,3'd0,3'd2,3'd1,3'd1,3'd1));
    feed(); tk(3); pulses(c0, c1, cs, ca);
    chk("R10 cpu0 width 1600ns", c0, 16); chk("R10 cpu1 width 1600ns", c1, 16);
    // R11 sys and aon
    wr(4'd0, mk(1,0,0,0,1,2'b00,3'd0,3'd7,3'd3,3'd1,3'd1,3'd1));
    feed(); tk(3); pulses(c0, c1, cs, ca);
    chk("R11 sys width 3200ns", cs, 32); chk("R11 aon idle", ca, 0);
    wr(4'd0, mk(1,0,0,0,1,2'b00,3'd0,3'd5,3'd4,3'd1,3'd1,3'd1));
    feed(); tk(3); pulses(c0, c1, cs, ca);
    chk("R11 aon width 800ns", ca, 8); chk("R11 sys idle", cs, 0);
    wr(4'd0, 32'd0);
    repeat (3) cyc(0, 0, 4'd0, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule